// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block gives each of two independent ports a small private message area of four 16-bit mailbox words and a signalling path to the other port. A port writes its own mailboxes. When it writes the upper byte of one, an interrupt request is raised toward the other port. The receiving port reads the message from its view of the sender's mailboxes. Reading the upper byte acknowledges the request and leaves the data unchanged. Each port has its own control word. That word holds a 4-bit mask for its incoming sources, a post-mask cause field, a pre-mask status field and an active-low interrupt output.

The model is synchronous and register-level. An access is sampled on a rising clock edge. Read data is registered and appears in the cycle after the access. Side effects take place at the edge on which the access is sampled. A port reaches this register space only while its mailbox select is low and its chip enable is inactive (high). Only the six low address bits are decoded.

Top module: `dpmbx_top`

## Requirements
- R1: An access takes effect only when the port's select input (active low) is 0 and its chip-enable input is 1. In any other cycle the port changes no state, and its read data in the next cycle is 0x0000.
- R2: Addresses 0b1000kk (k = 0..3) write the port's own mailbox k, one byte lane per enable (upper enable covers bits 15:8, lower enable covers bits 7:0). A read at the same address returns the stored word and does not change any interrupt state.
- R3: A write with the upper enable set at 0b1000kk marks source k pending at the opposite port. The pending value is 0 in that port's status bit 8+k, and also in its cause bit 4+k if the source is not masked. A write with only the lower enable set raises nothing.
- R4: Addresses 0b1001kk read the opposite port's mailbox k. A read with the upper enable set returns cause bit 4+k and status bit 8+k to 1 and leaves the mailbox data unchanged. A read with only the lower enable set clears nothing.
- R5: Address 0b101000 is the control word: mask in bits 3:0, cause in bits 7:4, status in bits 11:8, and bits 15:12 reading 0. A write with the lower enable set loads all four mask bits at once. Writes never alter the cause or status bits.
- R6: A mask bit of 1 blocks its source. A pending request to a masked source updates the status bit but leaves the cause bit untouched.
- R7: The interrupt output (active low) is 0 exactly while at least one cause bit of that port reads 0. It changes right after the edge that changes the cause field.
- R8: If a set and an acknowledge of the same source arrive in one cycle, the set wins and the source stays pending.
- R9: Every other address in mailbox space is reserved. A write there changes nothing, and a read there returns 0x0000.
- R10: A port's mask changes only through that port's own control-word write. The other port cannot alter it.
- R11: After reset every mask bit is 0, every cause and status bit is 1, all mailboxes hold 0, and both interrupt outputs are 1.
- R12: Read data is registered. It shows the state as it was before the edge on which the read is sampled, one cycle after that edge.
- R13: A byte lane whose enable is 0 in a read returns 0 in that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel_n | input | 1 | Port A mailbox select, active low |
| a_ce_n | input | 1 | Port A chip enable; must be 1 for a mailbox access |
| a_rd_wn | input | 1 | Port A direction: 1 read, 0 write |
| a_hi_en | input | 1 | Port A upper byte enable |
| a_lo_en | input | 1 | Port A lower byte enable |
| a_addr | input | 6 | Port A mailbox-space address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_sel_n | input | 1 | Port B mailbox select, active low |
| b_ce_n | input | 1 | Port B chip enable; must be 1 for a mailbox access |
| b_rd_wn | input | 1 | Port B direction: 1 read, 0 write |
| b_hi_en | input | 1 | Port B upper byte enable |
| b_lo_en | input | 1 | Port B lower byte enable |
| b_addr | input | 6 | Port B mailbox-space address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The embedded properties check the following on every cycle:
- a request always leaves its status bit pending, even when an acknowledge arrives in the same cycle;
- an acknowledge without a competing request releases both bits;
- a masked request never touches its cause bit;
- a cause bit never shows pending while its status bit is idle;
- the mask and mailbox words hold still unless their own write strobe fires;
- an unqualified cycle yields zero read data.

Only the bench's scenarios can show the parts that span both ports and the layout of returned words. These include the exact bit positions in the control word, byte-lane merging in the mailboxes, and the fact that one port's writes reach the other port's interrupt and never its mask. The bench covers them by sweeping every address with both directions on both ports, by running a long pseudo-random mix of both ports acting together, and by comparing each cycle with an arithmetic model.

// File: rtl/dpmbx_pkg.sv
// Package: shared constants and the decoded-access record for the
// dual-port mailbox interrupt controller.
// Assumes a 6-bit mailbox-space address and four mailboxes per port; the
// address map below depends on that count.
package dpmbx_pkg;

    localparam int ADDR_W   = 6;
    localparam int N_BOX    = 4;
    localparam int IDX_W    = $clog2(N_BOX);

    // Address map (six bits)
    localparam logic [ADDR_W-1:0] OWN_BASE  = 6'b100000;
    localparam logic [ADDR_W-1:0] PEER_BASE = 6'b100100;
    localparam logic [ADDR_W-1:0] CTL_ADDR  = 6'b101000;

    // One port's access, decoded for one cycle
    typedef struct packed {
        logic             access;
        logic             wr_own_lo;
        logic             wr_own_hi;
        logic             wr_ctl;
        logic             rd_own;
        logic             rd_peer;
        logic             rd_ctl;
        logic             rd_hi;
        logic             rd_lo;
        logic [IDX_W-1:0] idx;
    } mbx_op_t;

endpackage

// File: rtl/dpmbx_decode.sv
// Module: dpmbx_decode
// Turns one port's raw pins into a decoded access record for the current
// cycle. Purely combinational.
// Assumes the select is active low and the chip enable must be inactive
// (high) for mailbox space to be reached.
module dpmbx_decode
    import dpmbx_pkg::*;
(
    input  logic              sel_n,
    input  logic              ce_n,
    input  logic              rd_wn,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic [ADDR_W-1:0] addr,
    output mbx_op_t           op
);

    logic access;
    logic hit_own;
    logic hit_peer;
    logic hit_ctl;

    // Qualify the cycle and classify the address
    always_comb begin
        access   = !sel_n && ce_n;
        hit_own  = (addr[ADDR_W-1:IDX_W] == OWN_BASE[ADDR_W-1:IDX_W]);
        hit_peer = (addr[ADDR_W-1:IDX_W] == PEER_BASE[ADDR_W-1:IDX_W]);
        hit_ctl  = (addr == CTL_ADDR);
    end

    // Build the decoded record
    always_comb begin
        op.access    = access;
        op.wr_own_lo = access && !rd_wn && hit_own && lo_en;
        op.wr_own_hi = access && !rd_wn && hit_own && hi_en;
        op.wr_ctl    = access && !rd_wn && hit_ctl && lo_en;
        op.rd_own    = access && rd_wn && hit_own;
        op.rd_peer   = access && rd_wn && hit_peer;
        op.rd_ctl    = access && rd_wn && hit_ctl;
        op.rd_hi     = access && rd_wn && hi_en;
        op.rd_lo     = access && rd_wn && lo_en;
        op.idx       = addr[IDX_W-1:0];
    end

endmodule

// File: rtl/dpmbx_store.sv
// Module: dpmbx_store
// Holds one port's mailbox words, written byte by byte by that port only.
// All words are visible at once so both the owner and the peer can read.
// Assumes at most one word is written per cycle, selected by idx.
module dpmbx_store #(
    parameter int N  = 4,
    parameter int DW = 16,
    localparam int IW = $clog2(N),
    localparam int HB = DW / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic [IW-1:0]        idx,
    input  logic [DW-1:0]        wdata,
    output logic [N-1:0][DW-1:0] words
);

    // Byte-lane writes into the selected word; reset clears all words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else begin
            for (int w = 0; w < N; w++) begin
                if (wr_lo && (idx == IW'(w))) words[w][HB-1:0]  <= wdata[HB-1:0];
                if (wr_hi && (idx == IW'(w))) words[w][DW-1:HB] <= wdata[DW-1:HB];
            end
        end
    end

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hi || wr_lo) |=> $stable(words)); // R2

endmodule

// File: rtl/dpmbx_irq.sv
// Module: dpmbx_irq
// Interrupt bookkeeping for the receiving side of one port: mask, post-mask
// cause bits and pre-mask status bits (0 means pending), plus the active-low
// interrupt output.
// Assumes set_v comes from the opposite port and clr_v from this port's own
// acknowledging reads. A set beats a clear of the same source.
module dpmbx_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_d,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] cause_n,
    output logic [N-1:0] stat_n,
    output logic         irq_n
);

    // Mask register, written as a whole by this port only
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (mask_wr) mask_q <= mask_d;
    end

    // Pre-mask status: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_n <= '1;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (set_v[k])      stat_n[k] <= 1'b0;
                else if (clr_v[k]) stat_n[k] <= 1'b1;
            end
        end
    end

    // Post-mask cause: masked sets leave the bit alone, set blocks clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_n <= '1;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (set_v[k]) begin
                    if (!mask_q[k]) cause_n[k] <= 1'b0;
                end else if (clr_v[k]) begin
                    cause_n[k] <= 1'b1;
                end
            end
        end
    end

    // Interrupt while any cause bit is pending
    assign irq_n = &cause_n;

    AST_CAUSE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cause_n) & stat_n) == '0); // R6

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q)); // R10

    for (genvar k = 0; k < N; k++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[k] |=> !stat_n[k]); // R8

        AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[k] && !set_v[k]) |=> (stat_n[k] && cause_n[k])); // R4

        AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v[k] && mask_q[k] && cause_n[k]) |=> cause_n[k]); // R6
    end

endmodule

// File: rtl/dpmbx_top.sv
// Module: dpmbx_top
// Two-port mailbox interrupt controller. Each port owns four mailbox words
// and one control word. An upper-byte write signals the peer, and the
// peer's upper-byte read acknowledges the signal.
// Assumes synchronous accesses sampled on the rising edge. Read data is
// registered, and disabled or reserved lanes read as zero.
module dpmbx_top
    import dpmbx_pkg::*;
#(
    parameter int DW = 16,
    parameter int N  = N_BOX,
    localparam int IW = $clog2(N),
    localparam int HB = DW / 2,
    localparam int PAD_W = DW - 3 * N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_ce_n,
    input  logic              a_rd_wn,
    input  logic              a_hi_en,
    input  logic              a_lo_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DW-1:0]     a_wdata,
    output logic [DW-1:0]     a_rdata,
    output logic              a_irq_n,
    input  logic              b_sel_n,
    input  logic              b_ce_n,
    input  logic              b_rd_wn,
    input  logic              b_hi_en,
    input  logic              b_lo_en,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DW-1:0]     b_wdata,
    output logic [DW-1:0]     b_rdata,
    output logic              b_irq_n
);

    localparam int NP = 2;

    logic                 p_sel_n [NP];
    logic                 p_ce_n  [NP];
    logic                 p_rd_wn [NP];
    logic                 p_hi_en [NP];
    logic                 p_lo_en [NP];
    logic [ADDR_W-1:0]    p_addr  [NP];
    logic [DW-1:0]        p_wdata [NP];
    logic [DW-1:0]        p_rdata [NP];
    logic                 p_irq_n [NP];

    mbx_op_t              op          [NP];
    logic [N-1:0][DW-1:0] words       [NP];
    logic [N-1:0]         set_to_peer [NP];
    logic [N-1:0]         clr_own     [NP];
    logic [N-1:0]         mask_q      [NP];
    logic [N-1:0]         cause_n     [NP];
    logic [N-1:0]         stat_n      [NP];

    // Gather the two pin groups into per-port arrays
    assign p_sel_n[0] = a_sel_n;  assign p_sel_n[1] = b_sel_n;
    assign p_ce_n[0]  = a_ce_n;   assign p_ce_n[1]  = b_ce_n;
    assign p_rd_wn[0] = a_rd_wn;  assign p_rd_wn[1] = b_rd_wn;
    assign p_hi_en[0] = a_hi_en;  assign p_hi_en[1] = b_hi_en;
    assign p_lo_en[0] = a_lo_en;  assign p_lo_en[1] = b_lo_en;
    assign p_addr[0]  = a_addr;   assign p_addr[1]  = b_addr;
    assign p_wdata[0] = a_wdata;  assign p_wdata[1] = b_wdata;
    assign a_rdata    = p_rdata[0];
    assign b_rdata    = p_rdata[1];
    assign a_irq_n    = p_irq_n[0];
    assign b_irq_n    = p_irq_n[1];

    for (genvar p = 0; p < NP; p++) begin : g_port
        localparam int O = NP - 1 - p;

        logic [DW-1:0] rd_word;
        logic [DW-1:0] rd_lanes;
        logic [DW-1:0] rdata_q;

        dpmbx_decode u_dec (
            .sel_n (p_sel_n[p]),
            .ce_n  (p_ce_n[p]),
            .rd_wn (p_rd_wn[p]),
            .hi_en (p_hi_en[p]),
            .lo_en (p_lo_en[p]),
            .addr  (p_addr[p]),
            .op    (op[p])
        );

        dpmbx_store #(.N(N), .DW(DW)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hi (op[p].wr_own_hi),
            .wr_lo (op[p].wr_own_lo),
            .idx   (op[p].idx),
            .wdata (p_wdata[p]),
            .words (words[p])
        );

        // Upper-byte own writes signal the peer; upper-byte peer reads acknowledge
        assign set_to_peer[p] = op[p].wr_own_hi ? (N'(1) << op[p].idx) : '0;
        assign clr_own[p]     = (op[p].rd_peer && op[p].rd_hi) ? (N'(1) << op[p].idx) : '0;

        dpmbx_irq #(.N(N)) u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_v   (set_to_peer[O]),
            .clr_v   (clr_own[p]),
            .mask_wr (op[p].wr_ctl),
            .mask_d  (p_wdata[p][N-1:0]),
            .mask_q  (mask_q[p]),
            .cause_n (cause_n[p]),
            .stat_n  (stat_n[p]),
            .irq_n   (p_irq_n[p])
        );

        // Select the addressed word for a read
        always_comb begin
            rd_word = '0;
            if (op[p].rd_own)       rd_word = words[p][op[p].idx];
            else if (op[p].rd_peer) rd_word = words[O][op[p].idx];
            else if (op[p].rd_ctl)  rd_word = {{PAD_W{1'b0}}, stat_n[p], cause_n[p], mask_q[p]};
        end

        // Zero the byte lanes that are not enabled
        always_comb begin
            rd_lanes = {op[p].rd_hi ? rd_word[DW-1:HB] : {(DW-HB){1'b0}},
                        op[p].rd_lo ? rd_word[HB-1:0]  : {HB{1'b0}}};
        end

        // Register the read result (pre-update state)
        always_ff @(posedge clk) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_lanes;
        end

        assign p_rdata[p] = rdata_q;

        AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
            !op[p].access |=> (rdata_q == '0)); // R1

        AST_IRQ_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            !p_irq_n[p] |-> (stat_n[p] != '1)); // R7
    end

endmodule

// File: tb/tb_dpmbx_top.sv
// Bench for dpmbx_top: directed cases, a full address sweep on both ports,
// then a pseudo-random mix. Every cycle is compared with an arithmetic model.
module tb_dpmbx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n [2];
    logic        ce_n  [2];
    logic        rw    [2];
    logic        hi    [2];
    logic        lo    [2];
    logic [5:0]  ad    [2];
    logic [15:0] wd    [2];
    logic [15:0] rd    [2];
    logic        irq   [2];

    logic [15:0] mb  [2][4];
    logic [3:0]  msk [2];
    logic [3:0]  cs  [2];
    logic [3:0]  st  [2];

    int vectors = 0;
    int fails   = 0;
    logic [31:0] rs = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    dpmbx_top dut (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(sel_n[0]), .a_ce_n(ce_n[0]), .a_rd_wn(rw[0]), .a_hi_en(hi[0]),
        .a_lo_en(lo[0]), .a_addr(ad[0]), .a_wdata(wd[0]), .a_rdata(rd[0]), .a_irq_n(irq[0]),
        .b_sel_n(sel_n[1]), .b_ce_n(ce_n[1]), .b_rd_wn(rw[1]), .b_hi_en(hi[1]),
        .b_lo_en(lo[1]), .b_addr(ad[1]), .b_wdata(wd[1]), .b_rdata(rd[1]), .b_irq_n(irq[1])
    );

    task automatic idle_all();
        for (int p = 0; p < 2; p++) begin
            sel_n[p] = 1'b1; ce_n[p] = 1'b1; rw[p] = 1'b1;
            hi[p] = 1'b0; lo[p] = 1'b0; ad[p] = '0; wd[p] = '0;
        end
    endtask

    task automatic acc(input int p, input bit r, input bit h, input bit l,
                       input logic [5:0] a, input logic [15:0] d);
        sel_n[p] = 1'b0; ce_n[p] = 1'b1; rw[p] = r;
        hi[p] = h; lo[p] = l; ad[p] = a; wd[p] = d;
    endtask

    task automatic tally(input bit ok, input string tag, input int p,
                         input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s port %0d actual %h expected %h", tag, p, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] a);
        if (a[5:2] == 4'b1000) return "R2";
        if (a[5:2] == 4'b1001) return "R4";
        if (a == 6'b101000)    return "R5";
        return "R9";
    endfunction

    // One cycle: model next state and read data, then compare after the edge (R12)
    task automatic step(input string tag);
        logic [15:0] er [2];
        logic [15:0] nmb [2][4];
        logic [3:0]  nmsk [2], ncs [2], nst [2], sv [2], cv [2];
        logic [15:0] w;
        bit acc_ok;
        int k, o;
        nmb = mb; nmsk = msk; ncs = cs; nst = st;
        for (int p = 0; p < 2; p++) begin
            sv[p] = '0; cv[p] = '0; er[p] = '0;
        end
        for (int p = 0; p < 2; p++) begin
            acc_ok = !sel_n[p] && ce_n[p];
            k = int'(ad[p][1:0]);
            o = 1 - p;
            if (acc_ok && rw[p]) begin
                w = '0;
                if (ad[p][5:2] == 4'b1000)      w = mb[p][k];
                else if (ad[p][5:2] == 4'b1001) w = mb[o][k];
                else if (ad[p] == 6'b101000)    w = {4'h0, st[p], cs[p], msk[p]};
                er[p] = {hi[p] ? w[15:8] : 8'h00, lo[p] ? w[7:0] : 8'h00};
                if (ad[p][5:2] == 4'b1001 && hi[p]) cv[p][k] = 1'b1;
            end
            if (acc_ok && !rw[p]) begin
                if (ad[p][5:2] == 4'b1000) begin
                    if (lo[p]) nmb[p][k][7:0] = wd[p][7:0];
                    if (hi[p]) begin
                        nmb[p][k][15:8] = wd[p][15:8];
                        sv[o][k] = 1'b1;
                    end
                end
                if (ad[p] == 6'b101000 && lo[p]) nmsk[p] = wd[p][3:0];
            end
        end
        for (int q = 0; q < 2; q++) begin
            for (int j = 0; j < 4; j++) begin
                if (sv[q][j]) begin
                    nst[q][j] = 1'b0;
                    if (!msk[q][j]) ncs[q][j] = 1'b0;
                end else if (cv[q][j]) begin
                    nst[q][j] = 1'b1;
                    ncs[q][j] = 1'b1;
                end
            end
        end
        @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) begin
            tally(rd[p] == er[p], tag, p, rd[p], er[p]);
            tally(irq[p] == (ncs[p] == 4'hF), "R7 irq", p, {15'h0, irq[p]},
                  {15'h0, ncs[p] == 4'hF});
        end
        mb = nmb; msk = nmsk; cs = ncs; st = nst;
        @(negedge clk);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        idle_all();
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 4; k++) mb[p][k] = '0;
            msk[p] = '0; cs[p] = 4'hF; st[p] = 4'hF;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        step("R11 idle");
        idle_all(); acc(0, 1, 1, 1, 6'b101000, 0); acc(1, 1, 1, 1, 6'b101000, 0); step("R11 ctl");

        // R1: unqualified cycles do nothing
        idle_all(); sel_n[0] = 0; ce_n[0] = 0; rw[0] = 0; hi[0] = 1; lo[0] = 1;
        ad[0] = 6'b100000; wd[0] = 16'hBEEF; step("R1 ce active");
        idle_all(); sel_n[0] = 1; rw[0] = 0; hi[0] = 1; lo[0] = 1;
        ad[0] = 6'b100000; wd[0] = 16'hBEEF; step("R1 sel high");
        idle_all(); acc(0, 1, 1, 1, 6'b100000, 0); step("R1 readback");

        // R2: byte writes to own mailbox, lower only raises nothing
        idle_all(); acc(0, 0, 0, 1, 6'b100001, 16'h1234); step("R2 lo write");
        idle_all(); acc(0, 1, 1, 1, 6'b100001, 0); step("R2 readback");

        // R3: upper write raises peer interrupt
        idle_all(); acc(0, 0, 1, 0, 6'b100001, 16'hAB00); step("R3 hi write");
        idle_all(); acc(1, 1, 1, 1, 6'b101000, 0); step("R3 peer ctl");
        idle_all(); acc(0, 1, 1, 1, 6'b100001, 0); step("R2 own read keeps irq");

        // R4: lower-only peer read keeps pending, upper read acknowledges
        idle_all(); acc(1, 1, 0, 1, 6'b100101, 0); step("R4 lo peer read");
        idle_all(); acc(1, 1, 1, 1, 6'b100101, 0); step("R4 hi peer read");
        idle_all(); acc(1, 1, 1, 1, 6'b100101, 0); step("R4 data kept");

        // R6: masked source updates status only
        idle_all(); acc(1, 0, 0, 1, 6'b101000, 16'h0002); step("R6 mask");
        idle_all(); acc(0, 0, 1, 1, 6'b100001, 16'h5A5A); step("R6 masked set");
        idle_all(); acc(1, 1, 1, 1, 6'b101000, 0); step("R6 ctl");

        // R10: own mask write leaves peer mask alone
        idle_all(); acc(0, 0, 1, 1, 6'b101000, 16'h000F); step("R10 write");
        idle_all(); acc(1, 1, 1, 1, 6'b101000, 0); acc(0, 1, 1, 1, 6'b101000, 0); step("R10 read");

        // R8: set and acknowledge of the same source together
        idle_all(); acc(0, 0, 1, 1, 6'b100010, 16'hC0DE); step("R8 first set");
        idle_all(); acc(0, 0, 1, 1, 6'b100010, 16'hC1DE); acc(1, 1, 1, 1, 6'b100110, 0);
        step("R8 collide");
        idle_all(); acc(1, 1, 1, 1, 6'b101000, 0); step("R8 still pending");

        // R13: disabled lanes read zero
        idle_all(); acc(1, 1, 1, 0, 6'b101000, 0); step("R13 hi only");
        idle_all(); acc(0, 1, 0, 1, 6'b100010, 0); step("R13 lo only");

        // R9: reserved writes and reads
        idle_all(); acc(0, 0, 1, 1, 6'b000101, 16'hFFFF); acc(1, 0, 1, 1, 6'b111111, 16'hFFFF);
        step("R9 write");
        idle_all(); acc(0, 1, 1, 1, 6'b101001, 0); acc(1, 1, 1, 1, 6'b011010, 0); step("R9 read");

        // R5: control write cannot touch cause or status
        idle_all(); acc(1, 0, 1, 1, 6'b101000, 16'hFFF0); step("R5 write");
        idle_all(); acc(1, 1, 1, 1, 6'b101000, 0); step("R5 read");

        // Sweep every address, write then read, on each port
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 64; a++) begin
                idle_all(); acc(p, 0, 1, 1, 6'(a), 16'h3C00 ^ 16'(a * 257) ^ 16'(p * 4660));
                step(tag_of(6'(a)));
                idle_all(); acc(p, 1, 1, 1, 6'(a), 0);
                step(tag_of(6'(a)));
            end
        end

        // Pseudo-random mix of both ports
        for (int i = 0; i < 4000; i++) begin
            idle_all();
            for (int p = 0; p < 2; p++) begin
                rs = nxt(rs);
                sel_n[p] = (rs[3:0] == 4'h0);
                ce_n[p]  = (rs[7:4] != 4'h0);
                rw[p]    = rs[8];
                hi[p]    = rs[9] | rs[10];
                lo[p]    = rs[11] | rs[12];
                ad[p]    = (rs[15:13] == 3'd0) ? rs[21:16] : (6'b100000 | 6'(rs[19:16]));
                rs = nxt(rs);
                wd[p]    = rs[15:0];
            end
            step(tag_of(ad[0]));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule